// File: doc/BRIEF.md
# Masked priority interrupt resolver

This block arbitrates among eight interrupt lines for a single processor. It keeps three 8-bit registers: a pending register that records lines which have asked for service, a service register that records levels whose handlers are running, and a block register whose set bits hide lines from arbitration. From these it decides whether to raise its interrupt output and which level should be serviced next.

Levels are ranked by fixed priority, with level 0 the most urgent. A pending, unblocked level interrupts the processor only if it outranks every level already in service. Nested handling therefore happens only where it is allowed. The processor takes the winner with an acknowledge pulse, which moves it from pending to in-service. It retires the most urgent running handler with an end-of-service pulse. Software writes the block register through a simple write strobe, and all three registers can be read back at the ports.

Top module: `irq_resolver`

## Requirements
- R1: While reset is asserted and until the first update after reset, the pending, service and block registers read 0, the interrupt output is low and the winner output is 0.
- R2: On each clock edge, every line sampled high sets its pending bit. A pending bit stays set until that level is acknowledged.
- R3: A write strobe loads the block register from the write data. Without the strobe the register holds its value. A level whose block bit is 1 never wins and never raises the interrupt, but its pending bit is still recorded.
- R4: The winner output gives the lowest-numbered level that is both pending and unblocked. It reads 0 when there is no such level.
- R5: The interrupt output is high exactly when a winner exists and either no service bit is set or the winner's number is lower than that of every set service bit.
- R6: An acknowledge while the interrupt output is high sets the winner's service bit and clears its pending bit. The clear takes effect even if the winner's line is high in the same cycle.
- R7: An acknowledge while the interrupt output is low changes neither the pending register nor the service register.
- R8: An end-of-service pulse clears only the lowest-numbered set service bit. With no service bit set, it has no effect.
- R9: An acknowledge and an end-of-service pulse in the same cycle both take effect: the winner's service bit is set, and the previously most urgent service bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 8 | Interrupt request lines, active high |
| mask_we_i | input | 1 | Write strobe for the block register |
| mask_d_i | input | 8 | Write data for the block register |
| ack_i | input | 1 | Processor acknowledge, one cycle per acknowledge |
| eoi_i | input | 1 | End-of-service command, one cycle per command |
| irq_o | output | 1 | Interrupt request to the processor |
| win_lvl_o | output | 3 | Number of the current winning level |
| req_o | output | 8 | Pending register readback |
| svc_o | output | 8 | Service register readback |
| mask_o | output | 8 | Block register readback |

## Verification
The hardest situation to reach is a deep nesting stack. In that state several service bits are set in strictly rising priority order, while a lower-priority request stays pending and blocked behind them. Random acknowledges and end-of-service pulses seldom build such a stack and then unwind it in order. The directed part of the stimulus therefore builds a stack by unblocking a more urgent level while a less urgent one is in service. It then retires the levels one at a time and checks that the blocked level reappears only when the last blocking level is gone. The random phase mixes sparse requests, frequent acknowledges, end-of-service pulses and occasional block writes. In this way simultaneous acknowledge and end-of-service pulses, and acknowledges with the interrupt low, occur many times.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_LVL = 8;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 8,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] one_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chain
      assign one_o[g]  = vec_i[g] & ~seen[g];
      assign seen[g+1] = seen[g] | vec_i[g];
    end
  endgenerate

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (one_o[i]) idx_o = idx_o | W'(i);
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = (q_o | line_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= pend_d;
  end
endmodule

// File: rtl/irq_svc_reg.sv
module irq_svc_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] svc_d;
  logic         svc_en;

  always_comb begin
    svc_en = |(set_i | clr_i);
    svc_d  = (q_o & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (svc_en) q_o <= svc_d;
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_pkg::*;
#(
  parameter int unsigned N_LVL = NUM_LVL,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] req_i,
  input  logic             mask_we_i,
  input  logic [N_LVL-1:0] mask_d_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [LW-1:0]    win_lvl_o,
  output logic [N_LVL-1:0] req_o,
  output logic [N_LVL-1:0] svc_o,
  output logic [N_LVL-1:0] mask_o
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [N_LVL-1:0] mask_d;
  logic [N_LVL-1:0] cand;
  logic             win_any, svc_any;
  logic [LW-1:0]    win_idx, svc_idx;
  logic [N_LVL-1:0] win_one, svc_one;
  logic [N_LVL-1:0] take_vec, retire_vec;
  logic             take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  always_comb begin
    mask_d = mask_we_i ? mask_d_i : mask_o;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    mask_o <= '0;
    else if (mask_we_i) mask_o <= mask_d;
  end

  assign cand = req_o & ~mask_o;

  irq_prio_pick #(.N(N_LVL), .W(LW)) u_pick_req (
    .vec_i (cand),
    .any_o (win_any),
    .idx_o (win_idx),
    .one_o (win_one)
  );

  irq_prio_pick #(.N(N_LVL), .W(LW)) u_pick_svc (
    .vec_i (svc_o),
    .any_o (svc_any),
    .idx_o (svc_idx),
    .one_o (svc_one)
  );

  always_comb begin
    irq_o      = win_any && (!svc_any || (win_idx < svc_idx));
    take       = ack_i && irq_o;
    take_vec   = take  ? win_one : '0;
    retire_vec = eoi_i ? svc_one : '0;
  end

  assign win_lvl_o = win_idx;

  irq_pend_reg #(.N(N_LVL)) u_pend (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .line_i (req_i),
    .clr_i  (take_vec),
    .q_o    (req_o)
  );

  irq_svc_reg #(.N(N_LVL)) u_svc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set_i  (take_vec),
    .clr_i  (retire_vec),
    .q_o    (svc_o)
  );
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned N_LVL = 8,
  parameter int unsigned LW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_LVL-1:0] req_i,
  input logic             mask_we_i,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             irq_o,
  input logic [LW-1:0]    win_lvl_o,
  input logic [N_LVL-1:0] req_o,
  input logic [N_LVL-1:0] svc_o,
  input logic [N_LVL-1:0] mask_o
);
  AST_IRQ_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_o[win_lvl_o] && !mask_o[win_lvl_o])); // R3
  AST_IRQ_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((svc_o << (N_LVL - 1 - win_lvl_o)) == '0)); // R5
  AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (svc_o[$past(win_lvl_o)] && !req_o[$past(win_lvl_o)])); // R6
  AST_SVC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi_i && !(ack_i && irq_o)) |=> $stable(svc_o)); // R7
  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && svc_o != '0) |=> ($countones(svc_o) == $countones($past(svc_o)) - 1)); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> ((req_o & $past(req_o)) == $past(req_o))); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_o)); // R3
endmodule

bind irq_resolver irq_resolver_chk #(.N_LVL(N_LVL), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .mask_we_i (mask_we_i),
  .ack_i     (ack_i),
  .eoi_i     (eoi_i),
  .irq_o     (irq_o),
  .win_lvl_o (win_lvl_o),
  .req_o     (req_o),
  .svc_o     (svc_o),
  .mask_o    (mask_o)
);

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_i;
  logic       mask_we_i;
  logic [7:0] mask_d_i;
  logic       ack_i;
  logic       eoi_i;
  logic       irq_o;
  logic [2:0] win_lvl_o;
  logic [7:0] req_o, svc_o, mask_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] m_req, m_svc, m_mask;

  always #2 clk = ~clk;

  irq_resolver u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_we_i(mask_we_i),
    .mask_d_i(mask_d_i), .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o),
    .win_lvl_o(win_lvl_o), .req_o(req_o), .svc_o(svc_o), .mask_o(mask_o)
  );

  function automatic logic lowest(input logic [7:0] v, output logic [2:0] idx);
    idx = 3'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) idx = 3'(i);
    return |v;
  endfunction

  function automatic logic exp_irq();
    logic [2:0] w, s;
    logic wa, sa;
    wa = lowest(m_req & ~m_mask, w);
    sa = lowest(m_svc, s);
    return wa && (!sa || w < s);
  endfunction

  function automatic logic [2:0] exp_win();
    logic [2:0] w;
    void'(lowest(m_req & ~m_mask, w));
    return w;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R5 irq", {7'd0, irq_o}, {7'd0, exp_irq()});
    chk("R4 winner", {5'd0, win_lvl_o}, {5'd0, exp_win()});
    chk("R2 pending", req_o, m_req);
    chk("R6 service", svc_o, m_svc);
    chk("R3 block", mask_o, m_mask);
  endtask

  task automatic step(input logic [7:0] r, input logic we, input logic [7:0] md,
                      input logic a, input logic e);
    logic [2:0] w, s;
    logic [7:0] take, ret;
    @(negedge clk);
    req_i = r; mask_we_i = we; mask_d_i = md; ack_i = a; eoi_i = e;
    void'(lowest(m_req & ~m_mask, w));
    take = (a && exp_irq()) ? (8'd1 << w) : 8'd0;
    ret  = (e && lowest(m_svc, s)) ? (8'd1 << s) : 8'd0;
    @(posedge clk);
    #1;
    m_req  = (m_req | r) & ~take;
    m_svc  = (m_svc & ~ret) | take;
    m_mask = we ? md : m_mask;
    check_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 8'h00; mask_we_i = 1'b0; mask_d_i = 8'h00;
    ack_i = 1'b0; eoi_i = 1'b0;
    m_req = 8'h00; m_svc = 8'h00; m_mask = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset irq", {7'd0, irq_o}, 8'h00);
    chk("R1 reset winner", {5'd0, win_lvl_o}, 8'h00);
    chk("R1 reset pending", req_o, 8'h00);
    chk("R1 reset service", svc_o, 8'h00);
    chk("R1 reset block", mask_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_all();

    // directed: block level 2, requests on 2 and 5
    step(8'h00, 1'b1, 8'h04, 1'b0, 1'b0);
    step(8'h24, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R3 blocked level recorded", req_o, 8'h24);
    chk("R4 winner skips blocked", {5'd0, win_lvl_o}, 8'h05);
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 ack sets service", svc_o, 8'h20);
    chk("R6 ack clears pending", req_o, 8'h04);
    // acknowledge with irq low is ignored
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R7 ack ignored service", svc_o, 8'h20);
    chk("R7 ack ignored pending", req_o, 8'h04);
    // unblock level 2: nests over level 5
    step(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
    chk("R5 nested irq", {7'd0, irq_o}, 8'h01);
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 nested service", svc_o, 8'h24);
    // level 6 blocked by both
    step(8'h40, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5 lower level held off", {7'd0, irq_o}, 8'h00);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 retire most urgent", svc_o, 8'h20);
    chk("R5 still held off", {7'd0, irq_o}, 8'h00);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R5 released", {7'd0, irq_o}, 8'h01);
    chk("R4 released winner", {5'd0, win_lvl_o}, 8'h06);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 empty retire", svc_o, 8'h00);
    // ack with line held high: clear wins
    step(8'h40, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 clear beats set", req_o, 8'h00);
    step(8'h02, 1'b0, 8'h00, 1'b0, 1'b0);
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R9 ack and retire together", svc_o, 8'h02);

    // random phase
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] r;
      r = ($urandom % 4 == 0) ? 8'($urandom & $urandom) : 8'h00;
      step(r, ($urandom % 10) == 0, 8'($urandom & $urandom),
           ($urandom % 2) == 0, ($urandom % 4) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule